// File: doc/BRIEF.md
# PHY Power-Up and DLL Lock Sequencer

This block is a hardware state machine that brings the analog front end of a storage-card PHY up or down. A requester posts a power-on or power-off request together with the measured rate of the card clock in hertz. A rate of zero means that no clock is running. The sequencer first drives both the analog power enable and the DLL enable low. For a power-off request it stops there. For a power-on request it waits a settle time, raises the power enable and waits for the calibration status. It then programs a frequency band, enables the DLL and, when a clock is present, waits for the lock status.

Every wait is measured in cycles of a reference clock. The reference frequency is a parameter, so the microsecond and millisecond limits come out exact. The calibration wait and the lock wait each have their own timeout, and each timeout ends the sequence with its own error flag. A warning flag marks clock rates that are too far from the ideal rate of their band, or above the top band.

The states are ST_IDLE, ST_DROP, ST_SETTLE, ST_CALWAIT, ST_BAND, ST_DLLON and ST_LOCKWAIT. The transitions are:
- ST_IDLE goes to ST_DROP on an accepted request.
- ST_DROP goes to ST_IDLE with success for a power-off request, and to ST_SETTLE for a power-on request.
- ST_SETTLE goes to ST_CALWAIT when the settle time ends.
- ST_CALWAIT goes to ST_BAND when calibration is seen, and to ST_IDLE with a calibration error on timeout.
- ST_BAND always goes to ST_DLLON.
- ST_DLLON goes to ST_IDLE with success when the rate is zero, and to ST_LOCKWAIT otherwise.
- ST_LOCKWAIT goes to ST_IDLE with success when lock is seen, and to ST_IDLE with a lock error on timeout.

Top module: `phy_bringup_seq`

## Requirements
- R1: In the cycle after an accepted request, the power enable and the DLL enable are both low. For a power-off request, done rises one cycle later and neither enable rises.
- R2: For a power-on request, the power enable rises after exactly SETTLE_US microseconds of reference cycles spent in the settle state.
- R3: If calibration-done is not sampled high within CAL_TMO_US microseconds of the power enable rising, the sequence ends with err_cal high. At most one of done, err_cal and err_lock is high at any time.
- R4: freq_band is 0 for a zero rate. Otherwise it is 1 below 75 MHz, 2 from 75 MHz to below 125 MHz, 3 from 125 MHz to below 175 MHz, and 0 from 175 MHz upward.
- R5: freq_band takes its new value at least one cycle before dll_en rises, and it does not change while dll_en stays high. dll_en is raised only while the power enable is high.
- R6: With a zero rate, dll_en still rises, and done is reported in the same cycle without waiting for lock.
- R7: With a nonzero rate, if DLL-ready is not sampled high within LOCK_TMO_US microseconds of dll_en rising, the sequence ends with err_lock high.
- R8: rate_warn is raised on a power-on request when the rate exceeds 200 MHz, or when the rate exceeds 50 MHz and lies more than 15 MHz from its band's ideal rate. The ideal rates are 50, 100, 150 and 200 MHz for codes 1, 2, 3 and 0.
- R9: busy is high from the cycle after acceptance until the sequence ends. A request made while busy is ignored and does not change the outcome.
- R10: done, err_cal, err_lock and rate_warn hold their values in idle until the next accepted request clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_on | input | 1 | 1 requests power-on, 0 requests power-off |
| clk_rate_hz | input | 32 | Measured card clock rate in Hz, 0 means no clock |
| cal_done_i | input | 1 | Calibration-done status from the analog pad |
| dll_ready_i | input | 1 | Lock status from the DLL |
| ana_pwr_en | output | 1 | Analog power enable; low holds the PHY powered down |
| dll_en | output | 1 | DLL enable |
| freq_band | output | 2 | DLL frequency band code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished successfully |
| err_cal | output | 1 | Last sequence timed out waiting for calibration |
| err_lock | output | 1 | Last sequence timed out waiting for lock |
| rate_warn | output | 1 | Last power-on used an unsupported clock rate |

## Verification
The hardest situations to reach from the ports are the exact edges of the two timeouts. A status that arrives on the last sampled cycle must still count as success, and one that arrives a cycle later must count as a timeout. The bench drives the status inputs from a small behavioural model of the pad and the DLL. The model raises each status a chosen number of cycles after the matching enable rises, so runs can place it on the last in-window cycle, one cycle past it, or never. The lock window is shortened through its parameter so that the lock timeout fits in a short run. A bench check also places a request in the middle of a busy sequence to confirm that it is ignored.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DROP,
        ST_SETTLE,
        ST_CALWAIT,
        ST_BAND,
        ST_DLLON,
        ST_LOCKWAIT
    } seq_state_e;

    localparam logic [1:0] BAND_200 = 2'd0;
    localparam logic [1:0] BAND_50  = 2'd1;
    localparam logic [1:0] BAND_100 = 2'd2;
    localparam logic [1:0] BAND_150 = 2'd3;

    localparam logic [31:0] HZ_50M  = 32'd50_000_000;
    localparam logic [31:0] HZ_75M  = 32'd75_000_000;
    localparam logic [31:0] HZ_100M = 32'd100_000_000;
    localparam logic [31:0] HZ_125M = 32'd125_000_000;
    localparam logic [31:0] HZ_150M = 32'd150_000_000;
    localparam logic [31:0] HZ_175M = 32'd175_000_000;
    localparam logic [31:0] HZ_200M = 32'd200_000_000;
    localparam logic [31:0] HZ_TOL  = 32'd15_000_000;

endpackage

// File: rtl/rate_classifier.sv
module rate_classifier
    import physeq_pkg::*;
(
    input  logic [31:0] rate_hz,
    output logic [1:0]  band,
    output logic        warn
);
    logic [31:0] ideal;
    logic [31:0] dev;

    always_comb begin
        if (rate_hz == 32'd0) begin
            band  = BAND_200;
            ideal = HZ_200M;
        end else if (rate_hz < HZ_75M) begin
            band  = BAND_50;
            ideal = HZ_50M;
        end else if (rate_hz < HZ_125M) begin
            band  = BAND_100;
            ideal = HZ_100M;
        end else if (rate_hz < HZ_175M) begin
            band  = BAND_150;
            ideal = HZ_150M;
        end else begin
            band  = BAND_200;
            ideal = HZ_200M;
        end
        dev  = (rate_hz > ideal) ? (rate_hz - ideal) : (ideal - rate_hz);
        warn = (rate_hz > HZ_200M) || ((rate_hz > HZ_50M) && (dev > HZ_TOL));
    end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (count != {W{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import physeq_pkg::*;
#(
    parameter int REF_HZ      = 250_000_000,
    parameter int SETTLE_US   = 3,
    parameter int CAL_TMO_US  = 50,
    parameter int LOCK_TMO_US = 50_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_on,
    input  logic [31:0] clk_rate_hz,
    input  logic        cal_done_i,
    input  logic        dll_ready_i,
    output logic        ana_pwr_en,
    output logic        dll_en,
    output logic [1:0]  freq_band,
    output logic        busy,
    output logic        done,
    output logic        err_cal,
    output logic        err_lock,
    output logic        rate_warn
);
    localparam longint CYC_PER_US = longint'(REF_HZ) / 1_000_000;
    localparam longint SETTLE_CYC = longint'(SETTLE_US) * CYC_PER_US;
    localparam longint CAL_CYC    = longint'(CAL_TMO_US) * CYC_PER_US;
    localparam longint LOCK_CYC   = longint'(LOCK_TMO_US) * CYC_PER_US;
    localparam longint MAX_CYC    = (LOCK_CYC > CAL_CYC) ?
                                    ((LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC) :
                                    ((CAL_CYC > SETTLE_CYC) ? CAL_CYC : SETTLE_CYC);
    localparam int     CNT_W      = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LAST    = CNT_W'(CAL_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_CYC - 1);

    seq_state_e       state_q, state_d;
    logic             on_q;
    logic [31:0]      rate_q;
    logic [CNT_W-1:0] elapsed;
    logic [1:0]       band_calc;
    logic             warn_calc;
    logic             accept, settle_end, cal_seen, cal_expire, lock_seen, lock_expire;

    rate_classifier u_class (
        .rate_hz (rate_q),
        .band    (band_calc),
        .warn    (warn_calc)
    );

    seq_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != state_d),
        .count (elapsed)
    );

    always_comb begin
        accept      = (state_q == ST_IDLE) && req_valid;
        settle_end  = (state_q == ST_SETTLE) && (elapsed == SETTLE_LAST);
        cal_seen    = (state_q == ST_CALWAIT) && cal_done_i;
        cal_expire  = (state_q == ST_CALWAIT) && !cal_done_i && (elapsed == CAL_LAST);
        lock_seen   = (state_q == ST_LOCKWAIT) && dll_ready_i;
        lock_expire = (state_q == ST_LOCKWAIT) && !dll_ready_i && (elapsed == LOCK_LAST);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_DROP;
            ST_DROP:     state_d = on_q ? ST_SETTLE : ST_IDLE;
            ST_SETTLE:   if (settle_end) state_d = ST_CALWAIT;
            ST_CALWAIT:  if (cal_seen) state_d = ST_BAND;
                         else if (cal_expire) state_d = ST_IDLE;
            ST_BAND:     state_d = ST_DLLON;
            ST_DLLON:    state_d = (rate_q == 32'd0) ? ST_IDLE : ST_LOCKWAIT;
            ST_LOCKWAIT: if (lock_seen || lock_expire) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            on_q    <= 1'b0;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                on_q   <= req_on;
                rate_q <= clk_rate_hz;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ana_pwr_en <= 1'b0;
            dll_en     <= 1'b0;
            freq_band  <= BAND_200;
            done       <= 1'b0;
            err_cal    <= 1'b0;
            err_lock   <= 1'b0;
            rate_warn  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    ana_pwr_en <= 1'b0;
                    dll_en     <= 1'b0;
                    done       <= 1'b0;
                    err_cal    <= 1'b0;
                    err_lock   <= 1'b0;
                    rate_warn  <= 1'b0;
                end
                ST_DROP: begin
                    if (on_q) rate_warn <= warn_calc;
                    else      done      <= 1'b1;
                end
                ST_SETTLE:   if (settle_end) ana_pwr_en <= 1'b1;
                ST_CALWAIT:  if (cal_expire) err_cal <= 1'b1;
                ST_BAND:     freq_band <= band_calc;
                ST_DLLON: begin
                    dll_en <= 1'b1;
                    if (rate_q == 32'd0) done <= 1'b1;
                end
                ST_LOCKWAIT: begin
                    if (lock_seen)   done     <= 1'b1;
                    if (lock_expire) err_lock <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       ana_pwr_en,
    input logic       dll_en,
    input logic [1:0] freq_band,
    input logic       busy,
    input logic       done,
    input logic       err_cal,
    input logic       err_lock
);
    a_r1_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (!ana_pwr_en && !dll_en && busy));

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_cal, err_lock}));

    a_r5_dll_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en) |-> ana_pwr_en);

    a_r5_band_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_en && $past(dll_en)) |-> $stable(freq_band));

    a_r9_busy_no_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !err_cal && !err_lock));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(req_valid) && !busy) |-> ($stable(done) && $stable(err_cal) && $stable(err_lock)));
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ana_pwr_en (ana_pwr_en),
    .dll_en     (dll_en),
    .freq_band  (freq_band),
    .busy       (busy),
    .done       (done),
    .err_cal    (err_cal),
    .err_lock   (err_lock)
);

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;
    localparam int REF_HZ = 1_000_000;
    localparam int SET_US = 3;
    localparam int CAL_US = 50;
    localparam int LCK_US = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_on = 1'b0;
    logic [31:0] clk_rate_hz = '0;
    logic cal_done_i = 1'b0, dll_ready_i = 1'b0;
    logic ana_pwr_en, dll_en, busy, done, err_cal, err_lock, rate_warn;
    logic [1:0] freq_band;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    // analog behaviour: status rises a chosen number of cycles after its enable
    int cal_lat = 5, lock_lat = 10;
    int pwr_cnt = 0, dll_cnt = 0;

    // reference model state
    int m_phase = 0, m_n = 0;
    bit m_on = 0;
    longint m_rate = 0;
    bit e_pwr = 0, e_dll = 0, e_done = 0, e_ec = 0, e_el = 0, e_warn = 0;
    int e_band = 0;

    always #2 clk = ~clk;

    phy_bringup_seq #(.REF_HZ(REF_HZ), .SETTLE_US(SET_US), .CAL_TMO_US(CAL_US),
                      .LOCK_TMO_US(LCK_US)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .clk_rate_hz(clk_rate_hz), .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
        .ana_pwr_en(ana_pwr_en), .dll_en(dll_en), .freq_band(freq_band), .busy(busy),
        .done(done), .err_cal(err_cal), .err_lock(err_lock), .rate_warn(rate_warn));

    function automatic int band_of(longint r);
        if (r == 0) return 0;
        if (r < 75_000_000) return 1;
        if (r < 125_000_000) return 2;
        if (r < 175_000_000) return 3;
        return 0;
    endfunction

    function automatic bit warn_of(longint r);
        longint ideal, d;
        int b = band_of(r);
        ideal = (b == 1) ? 50_000_000 : (b == 2) ? 100_000_000 :
                (b == 3) ? 150_000_000 : 200_000_000;
        d = (r > ideal) ? r - ideal : ideal - r;
        return (r > 200_000_000) || (r > 50_000_000 && d > 15_000_000);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // model advances on each rising edge using the inputs held there
    always @(posedge clk) begin
        int prev;
        prev = m_phase;
        if (!rst_n) begin
            m_phase = 0; e_pwr = 0; e_dll = 0; e_band = 0;
            e_done = 0; e_ec = 0; e_el = 0; e_warn = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_phase = 1; m_on = req_on; m_rate = longint'(clk_rate_hz);
                    e_pwr = 0; e_dll = 0; e_done = 0; e_ec = 0; e_el = 0; e_warn = 0;
                end
                1: if (!m_on) begin m_phase = 0; e_done = 1; end
                   else begin m_phase = 2; e_warn = warn_of(m_rate); end
                2: if (m_n == SET_US - 1) begin e_pwr = 1; m_phase = 3; end
                3: if (cal_done_i) m_phase = 4;
                   else if (m_n == CAL_US - 1) begin m_phase = 0; e_ec = 1; end
                4: begin e_band = band_of(m_rate); m_phase = 5; end
                5: begin e_dll = 1;
                       if (m_rate == 0) begin m_phase = 0; e_done = 1; end
                       else m_phase = 6;
                   end
                6: if (dll_ready_i) begin m_phase = 0; e_done = 1; end
                   else if (m_n == LCK_US - 1) begin m_phase = 0; e_el = 1; end
                default: m_phase = 0;
            endcase
        end
        m_n = (prev != m_phase) ? 0 : m_n + 1;
    end

    // compare every cycle, then update the analog status
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1/R2 ana_pwr_en", ana_pwr_en, e_pwr);
            chk("R5/R6 dll_en", dll_en, e_dll);
            chk("R4 freq_band", freq_band, e_band);
            chk("R9 busy", busy, m_phase != 0);
            chk("R10 done", done, e_done);
            chk("R3 err_cal", err_cal, e_ec);
            chk("R7 err_lock", err_lock, e_el);
            chk("R8 rate_warn", rate_warn, e_warn);
        end
        pwr_cnt = ana_pwr_en ? pwr_cnt + 1 : 0;
        dll_cnt = dll_en ? dll_cnt + 1 : 0;
        cal_done_i  <= ana_pwr_en && (pwr_cnt > cal_lat);
        dll_ready_i <= dll_en && (dll_cnt > lock_lat);
    end

    task automatic run(bit on, longint rate, int cl, int ll);
        cal_lat = cl; lock_lat = ll;
        @(negedge clk);
        req_valid = 1; req_on = on; clk_rate_hz = 32'(rate);
        @(negedge clk);
        req_valid = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R1 reset pwr", ana_pwr_en, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 power-off
        run(0, 100_000_000, 5, 10);
        chk("R1 off done", done, 1);
        // R4 R8 band sweep with normal lock
        run(1, 100_000_000, 5, 10);
        chk("R4 band 100M", freq_band, 2);
        run(1, 60_000_000, 4, 20);
        chk("R4 band 60M", freq_band, 1);
        run(1, 70_000_000, 4, 3);
        chk("R8 warn 70M", rate_warn, 1);
        run(1, 30_000_000, 4, 3);
        chk("R8 no warn 30M", rate_warn, 0);
        run(1, 130_000_000, 4, 3);
        chk("R4 band 130M", freq_band, 3);
        run(1, 180_000_000, 4, 3);
        chk("R8 warn 180M", rate_warn, 1);
        run(1, 250_000_000, 4, 3);
        chk("R8 warn 250M", rate_warn, 1);
        run(1, 124_999_999, 4, 3);
        chk("R4 band edge", freq_band, 2);
        // R6 zero rate: no lock wait, lock never comes
        run(1, 0, 4, 100_000);
        chk("R6 done", done, 1);
        chk("R6 dll_en", dll_en, 1);
        chk("R6 band", freq_band, 0);
        // R3 calibration window edges
        run(1, 100_000_000, CAL_US - 1, 3);
        chk("R3 late in window", done, 1);
        run(1, 100_000_000, CAL_US, 3);
        chk("R3 just too late", err_cal, 1);
        run(1, 100_000_000, 100_000, 3);
        chk("R3 never", err_cal, 1);
        // R10 hold in idle
        repeat (10) @(negedge clk);
        chk("R10 hold", err_cal, 1);
        // R7 lock timeout and last in-window
        run(1, 100_000_000, 4, LCK_US - 1);
        chk("R7 late lock ok", done, 1);
        run(1, 100_000_000, 4, 100_000);
        chk("R7 lock timeout", err_lock, 1);
        // R9 request mid-sequence ignored
        cal_lat = 5; lock_lat = 30;
        @(negedge clk); req_valid = 1; req_on = 1; clk_rate_hz = 32'd150_000_000;
        @(negedge clk); req_valid = 0;
        repeat (8) @(negedge clk);
        req_valid = 1; req_on = 0; clk_rate_hz = 32'd0;
        @(negedge clk); req_valid = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R9 ignored request", freq_band, 3);
        chk("R9 ignored done", done, 1);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule